// File: doc/BRIEF.md
# Lockable Watchdog Timer

The block is a watchdog counter for a chip's system controller. It counts qualified ticks of its input clock and, when the count for the selected timeout is reached, raises a one-cycle system reset request. Software keeps it quiet by issuing a kick strobe before the timeout elapses. A 4-bit control register, written and read over a simple register port, selects one of four timeout lengths and starts or stops the watchdog.

The control register also carries an active-low lock bit. Writing it to zero starts the watchdog and locks it, and the stop control no longer has any effect. Software cannot set the lock bit back to one. Only the block's reset can release it. This prevents errant code from disabling the safety net.

The timeout lengths are powers of two set by `BASE_LOG`. With the default of 9 they are 512, 2048, 16384 and 131072 ticks. From a 32 kHz tick source this gives 15.625 ms, 62.5 ms, 0.5 s and 4 s.

Top module: `wdog_top`

## Requirements
- R1: After reset, `rd_data_o` reads 4'b1111 and `rst_req_o` is low.
- R2: Control field positions are as follows. Bit 3 is the active-low lock. Bit 2 is the stop bit. Bits 1:0 are the timeout select. `rd_data_o` returns the last written value, except for the lock rule of R8.
- R3: For select values 0, 1, 2 and 3, the timeout is L = 2^B, 2^(B+2), 2^(B+5) and 2^(B+8) ticks, where B = `BASE_LOG`. The request pulse is visible in the cycle after the L-th counting edge that follows a counter clear or start.
- R4: The request is high for exactly one cycle. The counter restarts from zero at that edge, so the next request follows L ticks later.
- R5: A high `kick_i` clears the counter at the next edge, in both unlocked and locked modes. No request is raised in the cycle after a kick.
- R6: While unlocked, a stop bit of 1 stops the watchdog and holds the counter at zero. A stop bit of 0 runs it. Restarting always counts a full L.
- R7: Writing the lock bit as 0 enables the watchdog. While locked, the stop bit is stored but ignored.
- R8: Once cleared, the lock bit stays 0 on any write. Only `rst_ni` sets it back to 1.
- R9: A register write that changes the select field clears the counter at that edge.
- R10: The counter advances only on edges where `tick_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count enable from the slow or system time base |
| kick_i | input | 1 | Retrigger strobe, clears the counter |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 4 | Control register write data |
| rd_data_o | output | 4 | Control register read data |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The assertions check several properties on every cycle:
- the request lasts a single cycle;
- the lock bit never returns to one without reset;
- a stopped watchdog, a kick or a missing tick never produces a request in the following cycle;
- the counter never exceeds the selected limit.

The exact timeout lengths for every select value can only be shown by the bench's measured scenarios. The same holds for the restart after a request, the full recount after a kick mid-period, after a stop, or after a select change, and the ignored stop bit while locked.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef struct packed {
    logic       lock_n;
    logic       halt;
    logic [1:0] sel;
  } wdog_ctrl_t;

  localparam logic [3:0] CTRL_RST = 4'b1111;

  // timeout exponent for a select value
  function automatic int unsigned div_log(int unsigned base_log, logic [1:0] sel);
    case (sel)
      2'd0:    return base_log;
      2'd1:    return base_log + 2;
      2'd2:    return base_log + 5;
      default: return base_log + 8;
    endcase
  endfunction
endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
  import wdog_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [3:0] wr_data_i,
  output wdog_ctrl_t ctrl_o,
  output logic       sel_chg_o
);
  wdog_ctrl_t ctrl_q, wr_d;

  assign wr_d = wdog_ctrl_t'(wr_data_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= wdog_ctrl_t'(CTRL_RST);
    end else if (wr_en_i) begin
      ctrl_q.lock_n <= ctrl_q.lock_n & wr_d.lock_n; // one-way clear
      ctrl_q.halt   <= wr_d.halt;
      ctrl_q.sel    <= wr_d.sel;
    end
  end

  assign sel_chg_o = wr_en_i && (wr_d.sel != ctrl_q.sel);
  assign ctrl_o    = ctrl_q;
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned BASE_LOG = 9,
  parameter int unsigned CNT_W    = BASE_LOG + 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [1:0]       sel_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, lim_m1;
  logic             hit, expire_q;

  always_comb
    lim_m1 = CNT_W'((64'd1 << wdog_pkg::div_log(BASE_LOG, sel_i)) - 64'd1);

  assign hit = run_i && !clr_i && tick_i && (cnt_q == lim_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      expire_q <= 1'b0;
    end else begin
      expire_q <= hit;
      if (!run_i || clr_i || hit) cnt_q <= '0;
      else if (tick_i)            cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o    = cnt_q;
  assign expire_o = expire_q;
endmodule

// File: rtl/wdog_top.sv
module wdog_top #(
  parameter int unsigned BASE_LOG = 9
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       kick_i,
  input  logic       wr_en_i,
  input  logic [3:0] wr_data_i,
  output logic [3:0] rd_data_o,
  output logic       rst_req_o
);
  localparam int unsigned CNT_W = BASE_LOG + 8;

  wdog_pkg::wdog_ctrl_t ctrl;
  logic                 sel_chg, run;
  logic [CNT_W-1:0]     cnt;

  wdog_ctrl_reg u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .ctrl_o    (ctrl),
    .sel_chg_o (sel_chg)
  );

  // locked forces run, halt ignored
  assign run = !ctrl.lock_n || !ctrl.halt;

  wdog_counter #(.BASE_LOG(BASE_LOG), .CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .tick_i   (tick_i),
    .clr_i    (kick_i | sel_chg),
    .sel_i    (ctrl.sel),
    .cnt_o    (cnt),
    .expire_o (rst_req_o)
  );

  assign rd_data_o = ctrl;
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
  parameter int unsigned BASE_LOG = 9,
  parameter int unsigned CNT_W    = BASE_LOG + 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             kick_i,
  input logic [3:0]       rd_data_i,
  input logic             rst_req_i,
  input logic [CNT_W-1:0] cnt_i
);
  logic [CNT_W-1:0] lim_m1;
  always_comb
    lim_m1 = CNT_W'((64'd1 << wdog_pkg::div_log(BASE_LOG, rd_data_i[1:0])) - 64'd1);

  AST_PULSE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |=> !rst_req_i); // R4
  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_i[3] |=> !rd_data_i[3]); // R8
  AST_STOP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_i[3] && rd_data_i[2]) |=> !rst_req_i); // R6
  AST_KICK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> (!rst_req_i && cnt_i == '0)); // R5
  AST_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !rst_req_i); // R10
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= lim_m1); // R3
endmodule

bind wdog_top wdog_chk #(.BASE_LOG(BASE_LOG), .CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .kick_i    (kick_i),
  .rd_data_i (rd_data_o),
  .rst_req_i (rst_req_o),
  .cnt_i     (cnt)
);

// File: tb/wdog_top_tb.sv
module wdog_top_tb;
  localparam int B = 3;

  logic       clk = 1'b0, rst_ni = 1'b0, tick = 1'b1, kick = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_data = '0;
  logic [3:0] rd;
  logic       req;
  int tests = 0, fails = 0, n;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wdog_top #(.BASE_LOG(B)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .kick_i(kick),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd), .rst_req_o(req)
  );

  function automatic int lim(int s);
    case (s)
      0: return 1 << B;
      1: return 1 << (B + 2);
      2: return 1 << (B + 5);
      default: return 1 << (B + 8);
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_kick();
    @(negedge clk); kick = 1'b1;
    @(negedge clk); kick = 1'b0;
  endtask

  task automatic measure(int maxc, output int cnt);
    cnt = -1;
    for (int i = 1; i <= maxc; i++) begin
      @(posedge clk); @(negedge clk);
      if (req) begin cnt = i; break; end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    chk("R1 reset ctrl", int'(rd), 15);
    chk("R1 reset req", int'(req), 0);
    measure(100, n);
    chk("R6 stopped at reset", n, -1);

    for (int s = 0; s < 4; s++) begin
      wr({2'b10, 2'(s)});
      chk("R2 readback", int'(rd), 8 + s);
      measure(lim(s) + 5, n);
      chk("R3 timeout", n, lim(s));
      @(negedge clk);
      chk("R4 single pulse", int'(req), 0);
      measure(lim(s) + 5, n);
      chk("R4 restart period", n, lim(s) - 1);
      wr({2'b11, 2'(s)});
      wr({2'b10, 2'(s)});
      repeat (lim(s) / 2) @(negedge clk);
      do_kick();
      measure(lim(s) + 5, n);
      chk("R5 kick recount", n, lim(s));
      wr({2'b11, 2'(s)});
    end

    wr(4'b1000);
    repeat (5) @(negedge clk);
    wr(4'b1100);
    measure(20, n);
    chk("R6 halt no request", n, -1);
    wr(4'b1000);
    measure(40, n);
    chk("R6 full recount after halt", n, lim(0));

    wr(4'b1001);
    repeat (20) @(negedge clk);
    wr(4'b1000);
    measure(40, n);
    chk("R9 select change clears", n, lim(0));

    wr(4'b1100);
    tick = 1'b0;
    wr(4'b1000);
    measure(50, n);
    chk("R10 no tick no count", n, -1);
    tick = 1'b1;
    measure(20, n);
    chk("R10 tick counts", n, lim(0));

    wr(4'b0100);
    chk("R7 lock readback", int'(rd), 4);
    do_kick();
    measure(20, n);
    chk("R7 locked runs despite halt", n, lim(0));
    wr(4'b0111);
    measure(lim(3) + 5, n);
    chk("R7 locked long timeout", n, lim(3));
    wr(4'b1111);
    chk("R8 lock stays cleared", int'(rd), 7);
    do_kick();
    measure(lim(3) + 5, n);
    chk("R5 kick while locked", n, lim(3));

    @(negedge clk); rst_ni = 1'b0;
    repeat (2) @(negedge clk); rst_ni = 1'b1;
    chk("R8 reset releases lock", int'(rd), 15);
    measure(100, n);
    chk("R8 stopped after reset", n, -1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog timeout act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule